// File: doc/BRIEF.md
# Serial Loader for a Four-Channel 8-Bit DAC

This block is the digital front end of a four-channel, 8-bit digital-to-analog converter. A host sends 10-bit words, MSB first, over a serial clock and data pair. The first two bits of each word pick a channel and the remaining eight bits carry its code. Each channel has two registers in series. A completed word lands in the selected channel's input register. While the active-low update line is asserted, every DAC register copies its input register, so all four outputs change together.

Two framing schemes are supported and picked by a mode input. In three-wire mode, a falling edge on the active-low load line commits the word. In two-wire mode, a start condition opens a frame and a stop condition commits it. A start is the data line falling while the clock is high. A stop is the data line rising while the clock is high. A serial output always shows the oldest bit held in the shift register, so several devices can be chained on one data line. All asynchronous inputs pass through two-flop synchronizers before their edges are detected. Every detected edge therefore acts a few system clocks after it appears at the pins.

Top module: `serial_quad_dac_loader`

## Requirements
- R1: After reset all four DAC codes are 0 and the serial output is 0.
- R2: In three-wire mode each rising SCL edge shifts the data input into bit 0 of a 10-bit shift register. The serial output always equals bit 9 of that register, which is the bit shifted in ten edges earlier.
- R3: In three-wire mode a falling edge of the load input writes shift bits [7:0] into the input register selected by shift bits [9:8] (0 = channel A, 3 = channel D). The DAC codes do not change until an update.
- R4: While the update input is low, every DAC register copies its input register in the same cycle. While it is high, the DAC codes hold. Channel k appears on dacCodes[8k+7:8k].
- R5: In two-wire mode a start condition opens a frame. Inside the frame, data is sampled at each rising SCL edge and shifted in when SCL falls. A stop condition after at least 10 shifted bits commits the last 10 bits, decoded as in R3.
- R6: In two-wire mode a stop condition that follows fewer than 10 bits since the start writes no input register.
- R7: In two-wire mode, SCL pulses outside a frame do not shift, and the load input has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| twoWireMode | input | 1 | 1 = start/stop framing, 0 = load-strobe framing |
| sclIn | input | 1 | Serial clock (asynchronous) |
| sdaIn | input | 1 | Serial data (asynchronous) |
| loadNIn | input | 1 | Active-low load strobe, idles high |
| ldacNIn | input | 1 | Active-low simultaneous DAC update |
| sroOut | output | 1 | Serial output for daisy-chaining (shift MSB) |
| dacCodes | output | 32 | Four 8-bit DAC codes, channel A in the low byte |

## Verification
The assertions assume the serial inputs change slowly compared with the system clock. They also assume the data line is stable across every SCL edge, except for deliberate start and stop conditions while SCL is high. The stimulus holds each level for four system clocks and changes data only while SCL is low. Load and update pulses never coincide, so a commit and an update never fall in the same cycle. The mode input is changed only while the bus is idle.

// File: rtl/dacld_pkg.sv
package dacld_pkg;
  typedef struct packed {
    logic shiftEn;
    logic shiftBit;
    logic commit;
    logic update;
  } dpStrobe_t;
endpackage

// File: rtl/dacld_sync.sv
module dacld_sync #(
  parameter int WIDTH = 5,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rstN) stage[s] <= RST_VAL;
        else if (s == 0) stage[s] <= asyncIn;
        else stage[s] <= stage[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/dacld_ctrl.sv
module dacld_ctrl
  import dacld_pkg::*;
#(
  parameter int FRAME_W = 10
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      twoWire,
  input  logic      sclS,
  input  logic      sdaS,
  input  logic      loadNS,
  input  logic      ldacNS,
  output dpStrobe_t strobe
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic sclP, sdaP, loadP;
  logic inFrame, pendBit, pendValid;
  logic [CNT_W-1:0] bitCnt;

  logic sclRise, sclFall, sclHeld, startDet, stopDet, loadFall;

  assign sclRise  = sclS & ~sclP;
  assign sclFall  = ~sclS & sclP;
  assign sclHeld  = sclS & sclP;
  assign startDet = twoWire & sclHeld & sdaP & ~sdaS;
  assign stopDet  = twoWire & sclHeld & ~sdaP & sdaS;
  assign loadFall = loadP & ~loadNS;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclP  <= 1'b0;
      sdaP  <= 1'b1;
      loadP <= 1'b1;
    end else begin
      sclP  <= sclS;
      sdaP  <= sdaS;
      loadP <= loadNS;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFrame   <= 1'b0;
      pendBit   <= 1'b0;
      pendValid <= 1'b0;
      bitCnt    <= '0;
    end else if (!twoWire) begin
      inFrame   <= 1'b0;
      pendValid <= 1'b0;
    end else if (startDet) begin
      inFrame   <= 1'b1;
      pendValid <= 1'b0;
      bitCnt    <= '0;
    end else if (stopDet) begin
      inFrame   <= 1'b0;
      pendValid <= 1'b0;
    end else if (inFrame) begin
      if (sclRise) begin
        pendBit   <= sdaS;
        pendValid <= 1'b1;
      end else if (sclFall && pendValid) begin
        pendValid <= 1'b0;
        if (bitCnt != CNT_W'(FRAME_W)) bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.shiftEn  = twoWire ? (inFrame & sclFall & pendValid) : sclRise;
    strobe.shiftBit = twoWire ? pendBit : sdaS;
    strobe.commit   = twoWire ? (stopDet & inFrame & (bitCnt == CNT_W'(FRAME_W)))
                              : loadFall;
    strobe.update   = ~ldacNS;
  end

  // R6: the bit counter saturates at one full frame
  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(FRAME_W));

  // R5: a start opens a frame with an empty count
  p_start_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (inFrame && bitCnt == '0));

  // R7: outside a frame in two-wire mode no shift occurs
  p_idle_no_shift_r7: assert property (@(posedge clk) disable iff (!rstN)
    (twoWire && !inFrame) |-> !strobe.shiftEn);
endmodule

// File: rtl/dacld_datapath.sv
module dacld_datapath
  import dacld_pkg::*;
#(
  parameter int CHANNELS = 4,
  parameter int CODE_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpStrobe_t                  strobe,
  output logic                       sroOut,
  output logic [CHANNELS*CODE_W-1:0] dacCodes
);
  localparam int ADDR_W  = $clog2(CHANNELS);
  localparam int FRAME_W = ADDR_W + CODE_W;

  logic [FRAME_W-1:0] shiftReg;
  logic [CODE_W-1:0]  inReg  [CHANNELS];
  logic [CODE_W-1:0]  dacReg [CHANNELS];
  logic [ADDR_W-1:0]  addr;
  logic [CODE_W-1:0]  dataField;

  assign addr      = shiftReg[FRAME_W-1 -: ADDR_W];
  assign dataField = shiftReg[CODE_W-1:0];
  assign sroOut    = shiftReg[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) shiftReg <= '0;
    else if (strobe.shiftEn) shiftReg <= {shiftReg[FRAME_W-2:0], strobe.shiftBit};
  end

  // R2: shift moves every bit up by one and takes the new bit at the bottom
  p_shift_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftEn |=> (shiftReg == {$past(shiftReg[FRAME_W-2:0]), $past(strobe.shiftBit)}));

  generate
    for (genvar k = 0; k < CHANNELS; k++) begin : g_chan
      always_ff @(posedge clk) begin
        if (!rstN) inReg[k] <= '0;
        else if (strobe.commit && addr == ADDR_W'(k)) inReg[k] <= dataField;
      end

      always_ff @(posedge clk) begin
        if (!rstN) dacReg[k] <= '0;
        else if (strobe.update) dacReg[k] <= inReg[k];
      end

      assign dacCodes[k*CODE_W +: CODE_W] = dacReg[k];

      // R3: a commit writes only the addressed channel
      p_commit_hit_r3: assert property (@(posedge clk) disable iff (!rstN)
        (strobe.commit && addr == ADDR_W'(k)) |=> (inReg[k] == $past(dataField)));
      p_commit_miss_r3: assert property (@(posedge clk) disable iff (!rstN)
        (!strobe.commit || addr != ADDR_W'(k)) |=> $stable(inReg[k]));

      // R4: DAC register follows the input register only on update
      p_update_r4: assert property (@(posedge clk) disable iff (!rstN)
        strobe.update |=> (dacReg[k] == $past(inReg[k])));
      p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
        !strobe.update |=> $stable(dacReg[k]));
    end
  endgenerate
endmodule

// File: rtl/serial_quad_dac_loader.sv
module serial_quad_dac_loader
  import dacld_pkg::*;
#(
  parameter int CHANNELS = 4,
  parameter int CODE_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       twoWireMode,
  input  logic                       sclIn,
  input  logic                       sdaIn,
  input  logic                       loadNIn,
  input  logic                       ldacNIn,
  output logic                       sroOut,
  output logic [CHANNELS*CODE_W-1:0] dacCodes
);
  localparam int FRAME_W = $clog2(CHANNELS) + CODE_W;

  logic [4:0] rawIn, syncIn;
  dpStrobe_t strobe;

  assign rawIn = {twoWireMode, ldacNIn, loadNIn, sdaIn, sclIn};

  dacld_sync #(.WIDTH(5), .STAGES(SYNC_STAGES), .RST_VAL(5'b01110)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(rawIn), .syncOut(syncIn)
  );

  dacld_ctrl #(.FRAME_W(FRAME_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .twoWire(syncIn[4]), .sclS(syncIn[0]), .sdaS(syncIn[1]),
    .loadNS(syncIn[2]), .ldacNS(syncIn[3]),
    .strobe(strobe)
  );

  dacld_datapath #(.CHANNELS(CHANNELS), .CODE_W(CODE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .sroOut(sroOut), .dacCodes(dacCodes)
  );
endmodule

// File: tb/tb_serial_quad_dac_loader.sv
module tb_serial_quad_dac_loader;
  logic clk = 1'b0;
  logic rstN, twoWireMode, sclIn, sdaIn, loadNIn, ldacNIn;
  logic sroOut;
  logic [31:0] dacCodes;

  int errs = 0;
  int total = 0;
  logic [9:0] mdl = '0;
  logic [7:0] expDac [4];
  logic [7:0] expIn [4];

  always #10 clk = ~clk;

  serial_quad_dac_loader dut (
    .clk(clk), .rstN(rstN), .twoWireMode(twoWireMode), .sclIn(sclIn),
    .sdaIn(sdaIn), .loadNIn(loadNIn), .ldacNIn(ldacNIn),
    .sroOut(sroOut), .dacCodes(dacCodes)
  );

  task automatic w4();
    repeat (4) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] packExp();
    return {expDac[3], expDac[2], expDac[1], expDac[0]};
  endfunction

  task automatic chkDacs(input string req);
    chk(dacCodes == packExp(), req, dacCodes, packExp());
  endtask

  task automatic bit3(input logic b);
    sdaIn = b; w4();
    sclIn = 1'b1; w4();
    sclIn = 1'b0; w4();
    mdl = {mdl[8:0], b};
  endtask

  task automatic loadPulse();
    loadNIn = 1'b0; w4(); loadNIn = 1'b1; w4();
  endtask

  task automatic ldacPulse();
    ldacNIn = 1'b0; w4(); ldacNIn = 1'b1; w4();
    for (int k = 0; k < 4; k++) expDac[k] = expIn[k];
  endtask

  task automatic frame2w(input int n, input logic [15:0] bits);
    sclIn = 1'b0; w4(); sdaIn = 1'b1; w4();
    sclIn = 1'b1; w4(); sdaIn = 1'b0; w4();
    sclIn = 1'b0; w4();
    for (int i = n - 1; i >= 0; i--) begin
      sdaIn = bits[i]; w4();
      sclIn = 1'b1; w4();
      sclIn = 1'b0; w4();
      mdl = {mdl[8:0], bits[i]};
    end
    sdaIn = 1'b0; w4(); sclIn = 1'b1; w4(); sdaIn = 1'b1; w4();
    if (n >= 10) expIn[mdl[9:8]] = mdl[7:0];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end

  initial begin
    rstN = 1'b0; twoWireMode = 1'b0; sclIn = 1'b0; sdaIn = 1'b1;
    loadNIn = 1'b1; ldacNIn = 1'b1;
    for (int k = 0; k < 4; k++) begin expDac[k] = 8'h00; expIn[k] = 8'h00; end
    repeat (10) @(negedge clk);
    rstN = 1'b1;
    w4();
    chkDacs("R1 reset codes");
    chk(sroOut == 1'b0, "R1 reset sro", {31'd0, sroOut}, 32'd0);

    // R2/R3/R4: three-wire sweep over every code value
    for (int v = 0; v < 256; v++) begin
      logic [1:0] ch;
      logic [9:0] word;
      ch = 2'((v * 3 + v / 4) % 4);
      word = {ch, 8'(v)};
      for (int i = 9; i >= 0; i--) begin
        bit3(word[i]);
        chk(sroOut == mdl[9], "R2 sro follows shift MSB", {31'd0, sroOut}, {31'd0, mdl[9]});
      end
      if (v % 32 == 0) chkDacs("R3 codes held before load");
      loadPulse();
      expIn[ch] = 8'(v);
      if (v % 32 == 0) chkDacs("R3 codes held after load without update");
      ldacPulse();
      chkDacs("R4 code after update");
    end

    // R4: four loads, then one update moves all channels together
    for (int c = 0; c < 4; c++) begin
      logic [9:0] word;
      word = {2'(c), 8'(8'h11 * (c + 1))};
      for (int i = 9; i >= 0; i--) bit3(word[i]);
      loadPulse();
      expIn[c] = word[7:0];
    end
    chkDacs("R4 all held before update");
    ldacPulse();
    chkDacs("R4 simultaneous update");

    // R5: two-wire frames to every channel
    twoWireMode = 1'b1; sdaIn = 1'b1; w4(); w4();
    for (int c = 0; c < 4; c++) begin
      frame2w(10, {6'd0, 2'(c), 8'(8'hC0 + c * 5)});
      chk(sroOut == mdl[9], "R5 sro after frame", {31'd0, sroOut}, {31'd0, mdl[9]});
      ldacPulse();
      chkDacs("R5 two-wire commit");
    end
    // R5: longer frame keeps the last ten bits
    frame2w(12, {4'd0, 2'b10, 2'b01, 8'h3C});
    ldacPulse();
    chkDacs("R5 twelve-bit frame uses last ten");

    frame2w(10, {6'd0, 2'b11, 8'h5A});
    ldacPulse();
    chkDacs("R5 frame to channel D");

    // R6: short frame commits nothing
    frame2w(5, 16'b00111);
    ldacPulse();
    chkDacs("R6 short frame ignored");
    chk(sroOut == mdl[9], "R6 sro after short frame", {31'd0, sroOut}, {31'd0, mdl[9]});

    // R7: clock pulses outside a frame and a load pulse have no effect
    sclIn = 1'b0; w4(); sdaIn = 1'b0; w4();
    for (int i = 0; i < 3; i++) begin
      sclIn = 1'b1; w4(); sclIn = 1'b0; w4();
    end
    chk(sroOut == mdl[9], "R7 idle pulses do not shift", {31'd0, sroOut}, {31'd0, mdl[9]});
    loadPulse();
    ldacPulse();
    chkDacs("R7 load ignored in two-wire mode");

    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end
endmodule